// File: doc/BRIEF.md
# Hardware Result Averaging Unit

This block sits between an analog converter core and the result register that software reads. When started, it requests raw 12-bit conversions from the core one at a time. It either passes a single conversion straight through, or it sums a power-of-two number of them (4, 8, 16 or 32) and writes the truncated mean. One start can run a single set, or it can keep running set after set until a stop request arrives.

The result register has a completion flag. A read acknowledge clears it. A runtime switch selects what happens when a new result is ready and the previous one has not been read: the new result either replaces the old one, or it is dropped without notice and the unread value is kept.

Top module: `avg_unit`

## Requirements
- R1: After reset, `resultData` is 0, `doneFlag` is 0 and `convReq` is 0.
- R2: With `avgEn` low, each set is one conversion, and the raw 12-bit value is written unchanged as the result.
- R3: With `avgEn` high, `countSel` codes 0, 1, 2 and 3 select sets of 4, 8, 16 and 32 conversions. The result is the sum of the set shifted right by 2, 3, 4 and 5 bits, with truncation. The accumulator is at least 17 bits wide and never overflows.
- R4: `convReq` is a one-cycle strobe. It is high in the cycle after an accepted start, and in the cycle after each accepted sample, unless that sample ended a set with no further set to follow.
- R5: With continuous mode off, a start produces exactly one set, and the unit then goes idle. While idle, `rawValid` is ignored: the result and the flag do not change.
- R6: With `contEn` high at start, the unit starts a new set right after each completed set and writes a result for every set.
- R7: A `stopPulse` while running lets the current set complete and write its result, then the unit goes idle with a cleared accumulator. A `stopPulse` while idle has no effect.
- R8: `doneFlag` rises in the cycle after a result is written. A `readAck` cycle with no write clears it. If a write falls in the same cycle as `readAck`, the write wins and the flag stays set.
- R9: With `overwriteEn` low, a result that completes while `doneFlag` is set (and `readAck` is low) is discarded: `resultData` and `doneFlag` keep their values.
- R10: With `overwriteEn` high, every completed result replaces the register contents, whatever the state of `doneFlag`.
- R11: `avgEn`, `countSel` and `contEn` are captured at start. Changing them, or pulsing `startPulse`, while a run is active has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rawData | input | 12 | Raw conversion from the converter core |
| rawValid | input | 1 | `rawData` is valid this cycle |
| avgEn | input | 1 | Averaging enable (captured at start) |
| countSel | input | 2 | Set-size code: 0→4, 1→8, 2→16, 3→32 |
| contEn | input | 1 | Continuous mode (captured at start) |
| startPulse | input | 1 | Begin a run when idle |
| stopPulse | input | 1 | End a continuous run after the current set |
| overwriteEn | input | 1 | 1: new results replace unread ones |
| readAck | input | 1 | Result consumed; clears `doneFlag` |
| convReq | output | 1 | Request the next conversion (one-cycle strobe) |
| resultData | output | 12 | Averaged or single result |
| doneFlag | output | 1 | Completion flag |

## Verification
The bench runs every set size with extreme and random sample values. A wrong shift or a narrow accumulator would show up as a wrong or wrapped mean, most clearly with all samples at 4095 over 32 samples.

It fills the result register and then completes another set with protection on and then off. A design that ignores protection would lose the unread value, and one that applies it always would keep stale data. It also lands a read acknowledge exactly on the final sample, where a design that gives the clear priority would leave the flag low.

It stops a continuous run partway through a set, and changes settings and restarts mid-run. A design that aborts the set, keeps requesting conversions, or picks up the new set size would produce wrong results or extra strobes.

// File: rtl/avg_pkg.sv
package avg_pkg;
  // Strobes from the sequencer to the accumulator datapath.
  typedef struct packed {
    logic accClear;  // zero the running sum (start of a run)
    logic accAdd;    // add a sample that is not the last of its set
    logic commit;    // last sample of a set: form the mean and try to store it
  } avgStrobes_t;
endpackage

// File: rtl/avg_ctrl.sv
module avg_ctrl
  import avg_pkg::*;
#(
  parameter int SEL_W   = 2,
  parameter int MIN_LOG = 2,
  parameter int MAX_LOG = MIN_LOG + (1 << SEL_W) - 1,
  parameter int SH_W    = $clog2(MAX_LOG + 1),
  parameter int CNT_W   = MAX_LOG
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rawValid,
  input  logic             avgEn,
  input  logic [SEL_W-1:0] countSel,
  input  logic             contEn,
  input  logic             startPulse,
  input  logic             stopPulse,
  output logic             convReq,
  output logic             running,
  output logic [SH_W-1:0]  shiftAmt,
  output avgStrobes_t      strobes
);
  logic [CNT_W-1:0] sampleCnt;
  logic [CNT_W-1:0] lastIdx;
  logic             contMode;
  logic             stopPend;
  logic             lastSample;
  logic             keepGoing;

  // Index of the final sample of a set: 2^shift - 1.
  always_comb begin
    logic [CNT_W:0] setSize;
    setSize = {{CNT_W{1'b0}}, 1'b1} << shiftAmt;
    lastIdx = CNT_W'(setSize - 1'b1);
  end

  assign lastSample = running && rawValid && (sampleCnt == lastIdx);
  assign keepGoing  = contMode && !stopPend && !stopPulse;

  always_comb begin
    strobes          = '0;
    strobes.accClear = !running && startPulse;
    strobes.accAdd   = running && rawValid && !lastSample;
    strobes.commit   = lastSample;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      convReq   <= 1'b0;
      sampleCnt <= '0;
      shiftAmt  <= '0;
      contMode  <= 1'b0;
      stopPend  <= 1'b0;
    end else if (!running) begin
      convReq <= 1'b0;
      if (startPulse) begin
        running   <= 1'b1;
        convReq   <= 1'b1;
        sampleCnt <= '0;
        shiftAmt  <= avgEn ? (SH_W'(MIN_LOG) + SH_W'(countSel)) : '0;
        contMode  <= contEn;
        stopPend  <= 1'b0;
      end
    end else begin
      convReq <= 1'b0;
      if (stopPulse) stopPend <= 1'b1;
      if (rawValid) begin
        if (lastSample) begin
          sampleCnt <= '0;
          if (keepGoing) begin
            convReq <= 1'b1;
          end else begin
            running  <= 1'b0;
            contMode <= 1'b0;
            stopPend <= 1'b0;
          end
        end else begin
          sampleCnt <= sampleCnt + 1'b1;
          convReq   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/avg_datapath.sv
module avg_datapath
  import avg_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int MAX_LOG = 5,
  parameter int SH_W    = 3,
  parameter int ACC_W   = DATA_W + MAX_LOG
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rawData,
  input  logic [SH_W-1:0]   shiftAmt,
  input  avgStrobes_t       strobes,
  input  logic              overwriteEn,
  input  logic              readAck,
  output logic [DATA_W-1:0] resultData,
  output logic              doneFlag
);
  logic [ACC_W-1:0] accSum;
  logic [ACC_W-1:0] nextSum;
  logic [ACC_W-1:0] meanFull;
  logic             mayWrite;

  assign nextSum  = accSum + ACC_W'(rawData);
  assign meanFull = nextSum >> shiftAmt;
  assign mayWrite = !doneFlag || overwriteEn || readAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accSum <= '0;
    end else if (strobes.accClear || strobes.commit) begin
      accSum <= '0;
    end else if (strobes.accAdd) begin
      accSum <= nextSum;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultData <= '0;
      doneFlag   <= 1'b0;
    end else if (strobes.commit && mayWrite) begin
      resultData <= meanFull[DATA_W-1:0];
      doneFlag   <= 1'b1;
    end else if (readAck) begin
      doneFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/avg_unit.sv
module avg_unit
  import avg_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int SEL_W   = 2,
  parameter int MIN_LOG = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] rawData,
  input  logic              rawValid,
  input  logic              avgEn,
  input  logic [SEL_W-1:0]  countSel,
  input  logic              contEn,
  input  logic              startPulse,
  input  logic              stopPulse,
  input  logic              overwriteEn,
  input  logic              readAck,
  output logic              convReq,
  output logic [DATA_W-1:0] resultData,
  output logic              doneFlag
);
  localparam int MAX_LOG = MIN_LOG + (1 << SEL_W) - 1;
  localparam int SH_W    = $clog2(MAX_LOG + 1);
  localparam int ACC_W   = DATA_W + MAX_LOG;

  avgStrobes_t     strobes;
  logic [SH_W-1:0] shiftAmt;
  logic            running;

  avg_ctrl #(
    .SEL_W(SEL_W), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG), .SH_W(SH_W), .CNT_W(MAX_LOG)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .rawValid(rawValid), .avgEn(avgEn),
    .countSel(countSel), .contEn(contEn), .startPulse(startPulse),
    .stopPulse(stopPulse), .convReq(convReq), .running(running),
    .shiftAmt(shiftAmt), .strobes(strobes)
  );

  avg_datapath #(
    .DATA_W(DATA_W), .MAX_LOG(MAX_LOG), .SH_W(SH_W), .ACC_W(ACC_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .rawData(rawData), .shiftAmt(shiftAmt),
    .strobes(strobes), .overwriteEn(overwriteEn), .readAck(readAck),
    .resultData(resultData), .doneFlag(doneFlag)
  );
endmodule

// File: rtl/avg_unit_chk.sv
module avg_unit_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              rawValid,
  input logic              startPulse,
  input logic              overwriteEn,
  input logic              readAck,
  input logic              convReq,
  input logic [DATA_W-1:0] resultData,
  input logic              doneFlag,
  input logic              running
);
  // R4: a start seen while idle requests a conversion next cycle
  p_start_requests_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!running && startPulse) |=> (convReq && running));

  // R5: no request appears out of idle without a start
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !startPulse) |=> !convReq);

  // R8: a read with no sample arriving clears the flag
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (readAck && !rawValid) |=> !doneFlag);

  // R9: unread data is protected when overwrite is off
  p_protect_unread_r9: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !overwriteEn && !readAck) |=> (doneFlag && $stable(resultData)));

  // R5: the result register only moves on a sample
  p_result_needs_sample_r5: assert property (@(posedge clk) disable iff (!rstN)
    !rawValid |=> $stable(resultData));
endmodule

bind avg_unit avg_unit_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .rawValid(rawValid), .startPulse(startPulse),
  .overwriteEn(overwriteEn), .readAck(readAck), .convReq(convReq),
  .resultData(resultData), .doneFlag(doneFlag), .running(running)
);

// File: tb/test_avg_unit.sv
module test_avg_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] rawData = '0;
  logic        rawValid = 1'b0;
  logic        avgEn = 1'b0;
  logic [1:0]  countSel = '0;
  logic        contEn = 1'b0;
  logic        startPulse = 1'b0;
  logic        stopPulse = 1'b0;
  logic        overwriteEn = 1'b0;
  logic        readAck = 1'b0;
  logic        convReq;
  logic [11:0] resultData;
  logic        doneFlag;

  int vectors = 0;
  int misses = 0;
  int reqCount = 0;
  int reqUsed = 0;
  logic [11:0] expResult = '0;
  logic        expDone = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  avg_unit i_avg_unit (
    .clk(clk), .rstN(rstN), .rawData(rawData), .rawValid(rawValid),
    .avgEn(avgEn), .countSel(countSel), .contEn(contEn),
    .startPulse(startPulse), .stopPulse(stopPulse), .overwriteEn(overwriteEn),
    .readAck(readAck), .convReq(convReq), .resultData(resultData),
    .doneFlag(doneFlag)
  );

  // Count conversion requests as the converter would see them.
  always @(posedge clk) if (convReq) reqCount <= reqCount + 1;

  function automatic int setSize(input logic en, input logic [1:0] code);
    return en ? (4 << code) : 1;
  endfunction

  function automatic logic [11:0] meanOf(input int sum, input int n);
    return 12'(sum / n);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkOut(input string req);
    check(req, resultData, expResult);
    check(req, doneFlag, expDone);
  endtask

  task automatic pulseStart();
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic pulseRead();
    readAck = 1'b1;
    @(negedge clk);
    readAck = 1'b0;
    expDone = 1'b0;
  endtask

  // Answer one conversion request with value v.
  task automatic feed(input logic [11:0] v, input bit ackWith);
    int guard = 0;
    while (reqCount <= reqUsed && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 100) check("R4 request timeout", 0, 1);
    reqUsed++;
    if ($urandom_range(0, 1) == 1) @(negedge clk);
    rawData  = v;
    rawValid = 1'b1;
    readAck  = ackWith;
    @(negedge clk);
    rawValid = 1'b0;
    readAck  = 1'b0;
  endtask

  // Run one set of n samples (mode 0 random, 1 all max, 2 all zero).
  task automatic runSet(input int n, input bit ackLast, input int mode);
    int sum = 0;
    for (int i = 0; i < n; i++) begin
      logic [11:0] v;
      v = (mode == 1) ? 12'hFFF : (mode == 2) ? 12'h000 : 12'($urandom_range(0, 4095));
      sum += v;
      feed(v, ackLast && (i == n - 1));
    end
    if (!expDone || overwriteEn || ackLast) begin
      expResult = meanOf(sum, n);
      expDone = 1'b1;
    end
  endtask

  task automatic idleCheck(input string req);
    repeat (6) @(negedge clk);
    check(req, reqCount - reqUsed, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    checkOut("R1 reset");
    check("R1 convReq", convReq, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: single conversions pass straight through
    avgEn = 1'b0;
    overwriteEn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      pulseStart();
      check("R4 req after start", convReq, 1);
      runSet(1, 0, k == 0 ? 1 : 0);
      checkOut("R2 single");
    end
    idleCheck("R5 no request after single");

    // R3: every set size with random, max and zero data
    avgEn = 1'b1;
    for (int code = 0; code < 4; code++) begin
      for (int m = 0; m < 3; m++) begin
        countSel = 2'(code);
        pulseRead();
        pulseStart();
        runSet(setSize(1'b1, 2'(code)), 0, m);
        checkOut("R3 mean");
      end
      idleCheck("R5 single set ends idle");
    end

    // R5: samples while idle are ignored
    rawData = 12'h5A5; rawValid = 1'b1;
    @(negedge clk);
    rawValid = 1'b0;
    @(negedge clk);
    checkOut("R5 idle sample ignored");

    // R8: read clears the flag
    pulseRead();
    checkOut("R8 read clears");

    // R9: protection keeps unread result
    overwriteEn = 1'b0;
    countSel = 2'd0;
    pulseStart(); runSet(4, 0, 0); checkOut("R9 first write");
    pulseStart(); runSet(4, 0, 0); checkOut("R9 second dropped");
    // R8: read on the final sample lets the write in and keeps the flag
    pulseStart(); runSet(4, 1, 0); checkOut("R8 write beats read");

    // R10: overwrite replaces unread result
    overwriteEn = 1'b1;
    pulseStart(); runSet(4, 0, 0); checkOut("R10 overwrite");

    // R6 and R7: continuous run, then stop mid-set
    contEn = 1'b1;
    countSel = 2'd1;
    pulseStart();
    contEn = 1'b0;  // R11: captured at start
    for (int s = 0; s < 3; s++) begin
      runSet(8, 0, 0);
      checkOut("R6 continuous set");
    end
    begin
      int sum = 0;
      for (int i = 0; i < 8; i++) begin
        logic [11:0] v;
        v = 12'($urandom_range(0, 4095));
        sum += v;
        if (i == 3) begin
          stopPulse = 1'b1;
          @(negedge clk);
          stopPulse = 1'b0;
        end
        feed(v, 0);
      end
      expResult = meanOf(sum, 8); expDone = 1'b1;
      checkOut("R7 stop finishes set");
    end
    idleCheck("R7 idle after stop");
    // R7: stop while idle has no effect
    stopPulse = 1'b1; @(negedge clk); stopPulse = 1'b0;
    countSel = 2'd0;
    pulseStart(); runSet(4, 0, 0); checkOut("R7 idle stop ignored");
    idleCheck("R7 single after idle stop");

    // R11: setting changes and restart mid-run do nothing
    countSel = 2'd0;
    pulseStart();
    begin
      int sum = 0;
      for (int i = 0; i < 4; i++) begin
        logic [11:0] v;
        v = 12'($urandom_range(0, 4095));
        sum += v;
        if (i == 1) begin
          countSel = 2'd3; avgEn = 1'b0; contEn = 1'b1;
          pulseStart();
        end
        feed(v, 0);
      end
      expResult = meanOf(sum, 4); expDone = 1'b1;
      checkOut("R11 settings held");
    end
    idleCheck("R11 no extra set");
    contEn = 1'b0;

    // Random sets against the model
    for (int r = 0; r < 40; r++) begin
      avgEn = 1'($urandom_range(0, 1));
      countSel = 2'($urandom_range(0, 3));
      overwriteEn = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 2) == 0) pulseRead();
      pulseStart();
      runSet(setSize(avgEn, countSel), 1'($urandom_range(0, 3) == 0), 0);
      checkOut(overwriteEn ? "R10 random" : "R9 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule